// File: doc/BRIEF.md
# Clock Mode Transition Controller

This block decides what happens when the processor issues a sleep request. There are two running modes: a fast active mode and a slow subactive mode. When the direct-switch enable is set, the switch-interrupt enable is set and interrupts are not masked, a sleep request moves the core to the mode chosen by the target select without stopping program execution. The block halts the CPU for three cycles of the clock in use before the switch. From slow to fast it then waits for the oscillator to settle. Last, it runs a fixed 14-cycle interrupt-exception phase in the new clock.

In every other case the request becomes a real sleep. From active mode this is sleep, and from subactive mode it is subsleep. A sleep entered with interrupts masked is locked: no wake interrupt ends it, and only reset does. The fast and slow clocks are given as single-cycle tick enables on one block clock. The block counts ticks; it makes no clocks. A slow tick that stands for the watch clock divided by eight makes the 14 exception cycles equal 112 watch periods.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, cur_mode is 0 (active), clk_sel is 0 (fast), and cpu_halt, exc_start and done are all low. The cur_mode encoding is 0 active, 1 subactive, 2 sleep, 3 subsleep. The clk_sel encoding is 0 fast, 1 slow.
- R2: In a running mode, a sleep_req with direct_en low moves the block one cycle later to sleep (from active) or subsleep (from subactive), with cpu_halt high.
- R3: A sleep_req with direct_en high and direct_irq_en low also enters sleep or subsleep instead of switching.
- R4: A sleep_req with irq_mask high enters sleep or subsleep whatever the other enables are. That state ignores wake_irq and is left only by reset.
- R5: An unmasked sleep ends on wake_irq one cycle later and returns to the running mode it was entered from.
- R6: A direct switch (direct_en, direct_irq_en high, irq_mask low) first counts 3 ticks of the old mode's clock with cpu_halt high, while cur_mode and clk_sel keep the old mode. The mode then becomes target_sel (0 active, 1 subactive), and clk_sel follows it.
- R7: When the exception phase begins, exc_start pulses for one cycle. The phase lasts 14 ticks of the new mode's clock with cpu_halt low. Then done pulses for one cycle and the block is running in the new mode.
- R8: Going from subactive to active, a settling wait of 8 << settle_sel fast ticks (8 to 1024), with cpu_halt high, lies between the switch and the exception phase. settle_sel is captured with the sleep request.
- R9: A direct switch whose target equals the current mode keeps the mode and clock and inserts no settling wait, but still takes 3 + 14 ticks.
- R10: A sleep_req that arrives while a switch is in progress has no effect.
- R11: Going from active to subactive has no settling wait. The exception phase starts right after the 3 fast ticks and is counted in slow ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_tick | input | 1 | One-cycle enable marking a fast-clock cycle |
| slow_tick | input | 1 | One-cycle enable marking a slow-clock cycle |
| sleep_req | input | 1 | Sleep request strobe from the CPU |
| direct_en | input | 1 | Turns a sleep request into a direct mode switch |
| direct_irq_en | input | 1 | Enable of the switch-completion interrupt |
| irq_mask | input | 1 | Global interrupt mask |
| wake_irq | input | 1 | Wake interrupt for an unmasked sleep |
| target_sel | input | 1 | Target mode of a switch: 0 active, 1 subactive |
| settle_sel | input | 3 | Settling wait code, wait = 8 << code fast ticks |
| cur_mode | output | 2 | 0 active, 1 subactive, 2 sleep, 3 subsleep |
| clk_sel | output | 1 | Running clock: 0 fast, 1 slow |
| cpu_halt | output | 1 | CPU stopped (pre-switch, settling, sleep) |
| exc_start | output | 1 | One-cycle pulse at the start of exception handling |
| done | output | 1 | One-cycle pulse when exception handling ends |

## Verification
A wrong phase or mode register shows at the ports within one tick of the clock in use. cpu_halt, clk_sel or cur_mode then differ from the reference on the very next cycle. A tick counter that is off by one moves exc_start or done by one fast or slow tick. This makes the error visible within 8 cycles at the default tick spacing. A stale lock or a wrong captured settle code shows at a later point: at the first wake_irq, or when the settling wait ends early or late.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [2:0] {
    PH_RUN, PH_PRE, PH_SETTLE, PH_EXC, PH_SLEEP
  } phase_e;

  typedef enum logic {
    CLK_FAST = 1'b0,
    CLK_SLOW = 1'b1
  } clk_e;

  // settling wait length in fast ticks: 2^(code + base_log)
  function automatic int unsigned settle_len(input int unsigned code,
                                             input int unsigned base_log);
    return 32'd1 << (code + base_log);
  endfunction
endpackage

// File: rtl/cmt_tick_sel.sv
module cmt_tick_sel
  import cmt_pkg::*;
(
  input  logic fast_tick,
  input  logic slow_tick,
  input  clk_e domain,
  output logic tick
);
  assign tick = (domain == CLK_SLOW) ? slow_tick : fast_tick;
endmodule

// File: rtl/cmt_phase_cnt.sv
module cmt_phase_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  // last tick of the phase
  assign hit = tick && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/cmt_seq.sv
module cmt_seq
  import cmt_pkg::*;
#(
  parameter int PRE_CYC   = 3,
  parameter int EXC_CYC   = 14,
  parameter int WAIT_W    = 3,
  parameter int WAIT_LOG0 = 3,
  parameter int CNT_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              direct_en,
  input  logic              direct_irq_en,
  input  logic              irq_mask,
  input  logic              wake_irq,
  input  logic              target_sel,
  input  logic [WAIT_W-1:0] settle_sel,
  input  logic              hit,
  output phase_e            phase,
  output clk_e              mode,
  output logic              lock,
  output logic [CNT_W-1:0]  limit,
  output logic              cnt_clr,
  output logic              sw_evt,
  output logic              accept,
  output logic              exc_start,
  output logic              done
);
  phase_e            ph_q, ph_d;
  clk_e              mode_q, tgt_q;
  logic [WAIT_W-1:0] sel_q;
  logic              lock_q, exc_q, done_q, exc_go, fin;

  assign accept = (ph_q == PH_RUN) && sleep_req;

  always_comb begin
    ph_d   = ph_q;
    sw_evt = 1'b0;
    exc_go = 1'b0;
    fin    = 1'b0;
    unique case (ph_q)
      PH_RUN:
        if (sleep_req)
          ph_d = (direct_en && direct_irq_en && !irq_mask) ? PH_PRE : PH_SLEEP;
      PH_PRE:
        if (hit) begin
          sw_evt = 1'b1;
          if (mode_q == CLK_SLOW && tgt_q == CLK_FAST) ph_d = PH_SETTLE;
          else begin
            ph_d   = PH_EXC;
            exc_go = 1'b1;
          end
        end
      PH_SETTLE:
        if (hit) begin
          ph_d   = PH_EXC;
          exc_go = 1'b1;
        end
      PH_EXC:
        if (hit) begin
          ph_d = PH_RUN;
          fin  = 1'b1;
        end
      PH_SLEEP:
        if (wake_irq && !lock_q) ph_d = PH_RUN;
      default: ph_d = PH_RUN;
    endcase
  end

  always_comb begin
    unique case (ph_q)
      PH_PRE:    limit = CNT_W'(PRE_CYC);
      PH_SETTLE: limit = CNT_W'(settle_len(32'(sel_q), WAIT_LOG0));
      PH_EXC:    limit = CNT_W'(EXC_CYC);
      default:   limit = CNT_W'(1);
    endcase
  end

  assign cnt_clr = (ph_d != ph_q) || (ph_q == PH_RUN) || (ph_q == PH_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_RUN;
      mode_q <= CLK_FAST;
      tgt_q  <= CLK_FAST;
      sel_q  <= '0;
      lock_q <= 1'b0;
      exc_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      exc_q  <= exc_go;
      done_q <= fin;
      if (accept) begin
        tgt_q  <= clk_e'(target_sel);
        sel_q  <= settle_sel;
        lock_q <= irq_mask;
      end
      if (sw_evt) mode_q <= tgt_q;
    end
  end

  assign phase     = ph_q;
  assign mode      = mode_q;
  assign lock      = lock_q;
  assign exc_start = exc_q;
  assign done      = done_q;
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import cmt_pkg::*;
#(
  parameter int PRE_CYC   = 3,
  parameter int EXC_CYC   = 14,
  parameter int WAIT_W    = 3,
  parameter int WAIT_LOG0 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              sleep_req,
  input  logic              direct_en,
  input  logic              direct_irq_en,
  input  logic              irq_mask,
  input  logic              wake_irq,
  input  logic              target_sel,
  input  logic [WAIT_W-1:0] settle_sel,
  output logic [1:0]        cur_mode,
  output logic              clk_sel,
  output logic              cpu_halt,
  output logic              exc_start,
  output logic              done
);
  localparam int MAX_WAIT = 1 << ((1 << WAIT_W) - 1 + WAIT_LOG0);
  localparam int MAX_LEN  = (MAX_WAIT > EXC_CYC) ? MAX_WAIT : EXC_CYC;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  phase_e           phase;
  clk_e             mode;
  logic             lock, tick, hit, cnt_clr, sw_evt, accept;
  logic [CNT_W-1:0] limit;

  // named internal events for the checker
  logic busy, sleep_locked;

  cmt_tick_sel u_tick (
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .domain    (mode),
    .tick      (tick)
  );

  cmt_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (tick),
    .limit (limit),
    .hit   (hit)
  );

  cmt_seq #(
    .PRE_CYC   (PRE_CYC),
    .EXC_CYC   (EXC_CYC),
    .WAIT_W    (WAIT_W),
    .WAIT_LOG0 (WAIT_LOG0),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_req     (sleep_req),
    .direct_en     (direct_en),
    .direct_irq_en (direct_irq_en),
    .irq_mask      (irq_mask),
    .wake_irq      (wake_irq),
    .target_sel    (target_sel),
    .settle_sel    (settle_sel),
    .hit           (hit),
    .phase         (phase),
    .mode          (mode),
    .lock          (lock),
    .limit         (limit),
    .cnt_clr       (cnt_clr),
    .sw_evt        (sw_evt),
    .accept        (accept),
    .exc_start     (exc_start),
    .done          (done)
  );

  assign busy         = (phase == PH_PRE) || (phase == PH_SETTLE) || (phase == PH_EXC);
  assign sleep_locked = lock;
  assign cur_mode     = {phase == PH_SLEEP, mode == CLK_SLOW};
  assign clk_sel      = (mode == CLK_SLOW);
  assign cpu_halt     = (phase == PH_PRE) || (phase == PH_SETTLE) || (phase == PH_SLEEP);
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       wake_irq,
  input logic [1:0] cur_mode,
  input logic       clk_sel,
  input logic       cpu_halt,
  input logic       exc_start,
  input logic       done,
  input logic       busy,
  input logic       sw_evt,
  input logic       sleep_locked
);
  p_sleep_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode[1] |-> cpu_halt);

  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode[1] && sleep_locked) |=> (cur_mode == $past(cur_mode)));

  p_wake_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode[1] && !sleep_locked && wake_irq) |=> (cur_mode == {1'b0, $past(cur_mode[0])}));

  p_clk_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> $past(sw_evt));

  p_exc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> !exc_start);

  p_exc_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |-> !cpu_halt);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cpu_halt && !cur_mode[1]));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sleep_req) |=> !cur_mode[1]);
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req    (sleep_req),
  .wake_irq     (wake_irq),
  .cur_mode     (cur_mode),
  .clk_sel      (clk_sel),
  .cpu_halt     (cpu_halt),
  .exc_start    (exc_start),
  .done         (done),
  .busy         (busy),
  .sw_evt       (sw_evt),
  .sleep_locked (sleep_locked)
);

// File: tb/clk_mode_ctrl_test.sv
`timescale 1ns/1ps
module clk_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_tick = 1'b0, slow_tick = 1'b0;
  logic       sleep_req = 1'b0, direct_en = 1'b0, direct_irq_en = 1'b0;
  logic       irq_mask = 1'b0, wake_irq = 1'b0, target_sel = 1'b0;
  logic [2:0] settle_sel = 3'd0;
  logic [1:0] cur_mode;
  logic       clk_sel, cpu_halt, exc_start, done;

  int    checks = 0;
  int    failures = 0;
  int    tc = 0;
  string tag = "R1";

  // reference model: 0 run, 1 pre-switch, 2 settling, 3 exception, 4 sleep
  int m_st = 0, m_md = 0, m_tg = 0, m_cnt = 0, m_sel = 0, m_lk = 0;
  int m_exc = 0, m_done = 0;

  always #2.5 clk = ~clk;

  clk_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .sleep_req(sleep_req), .direct_en(direct_en), .direct_irq_en(direct_irq_en),
    .irq_mask(irq_mask), .wake_irq(wake_irq), .target_sel(target_sel),
    .settle_sel(settle_sel), .cur_mode(cur_mode), .clk_sel(clk_sel),
    .cpu_halt(cpu_halt), .exc_start(exc_start), .done(done)
  );

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic int wait_ticks(input int code);
    int w = 8;
    for (int i = 0; i < code; i++) w = w * 2;
    return w;
  endfunction

  task automatic model_step();
    int tk;
    m_exc = 0;
    m_done = 0;
    if (!rst_n) begin
      m_st = 0; m_md = 0; m_tg = 0; m_cnt = 0; m_sel = 0; m_lk = 0;
      return;
    end
    tk = (m_md == 1) ? int'(slow_tick) : int'(fast_tick);
    case (m_st)
      0: if (sleep_req) begin
           m_tg = int'(target_sel); m_sel = int'(settle_sel); m_lk = int'(irq_mask);
           m_cnt = 0;
           m_st = (direct_en && direct_irq_en && !irq_mask) ? 1 : 4;
         end
      1: if (tk != 0) begin
           m_cnt++;
           if (m_cnt == 3) begin
             m_cnt = 0;
             if (m_md == 1 && m_tg == 0) begin m_md = 0; m_st = 2; end
             else begin m_md = m_tg; m_st = 3; m_exc = 1; end
           end
         end
      2: if (fast_tick) begin
           m_cnt++;
           if (m_cnt == wait_ticks(m_sel)) begin m_cnt = 0; m_st = 3; m_exc = 1; end
         end
      3: if (tk != 0) begin
           m_cnt++;
           if (m_cnt == 14) begin m_cnt = 0; m_st = 0; m_done = 1; end
         end
      default: if (wake_irq && m_lk == 0) m_st = 0;
    endcase
  endtask

  task automatic compare();
    int e_mode, e_halt, act, exp;
    e_mode = (m_st == 4) ? m_md + 2 : m_md;
    e_halt = (m_st == 1 || m_st == 2 || m_st == 4) ? 1 : 0;
    exp = (e_mode << 4) | (m_md << 3) | (e_halt << 2) | (m_exc << 1) | m_done;
    act = (int'(cur_mode) << 4) | (int'(clk_sel) << 3) | (int'(cpu_halt) << 2)
        | (int'(exc_start) << 1) | int'(done);
    chk({tag, " {mode,clk,halt,exc,done}"}, act, exp);
  endtask

  task automatic cyc();
    tc++;
    fast_tick = (tc % 2 == 0);
    slow_tick = (tc % 8 == 3);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_irq = 1'b1; cyc(); wake_irq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    tag = "R1"; run(3);
    rst_n = 1'b1; run(4);
    chk("R1 cur_mode after reset", int'(cur_mode), 0);

    // R6 / R11 / R7: active -> subactive, with R10 requests mid-way
    tag = "R6_R11_R7";
    direct_en = 1; direct_irq_en = 1; irq_mask = 0; target_sel = 1;
    pulse_sleep();
    run(2);
    tag = "R10"; pulse_sleep();
    run(50); pulse_sleep();
    tag = "R6_R11_R7"; run(100);
    chk("R11 ends in subactive", int'(cur_mode), 1);
    chk("R6 slow clock selected", int'(clk_sel), 1);

    // R8: subactive -> active, code 2 captured, later change ignored
    tag = "R8"; target_sel = 0; settle_sel = 3'd2;
    pulse_sleep();
    settle_sel = 3'd7;
    run(150);
    chk("R8 ends in active", int'(cur_mode), 0);

    // R9: active with target active
    tag = "R9"; target_sel = 0; pulse_sleep(); run(50);
    chk("R9 stays active", int'(cur_mode), 0);

    // R2 / R5: plain sleep and wake from active
    tag = "R2"; direct_en = 0; pulse_sleep(); run(5);
    chk("R2 sleep entered", int'(cur_mode), 2);
    tag = "R5"; pulse_wake(); run(3);
    chk("R5 back to active", int'(cur_mode), 0);

    // move to subactive, then R3: interrupt disabled gives subsleep
    tag = "R6"; direct_en = 1; direct_irq_en = 1; target_sel = 1;
    pulse_sleep(); run(140);
    tag = "R3"; direct_irq_en = 0; pulse_sleep(); run(5);
    chk("R3 subsleep entered", int'(cur_mode), 3);
    tag = "R5"; pulse_wake(); run(3);
    chk("R5 back to subactive", int'(cur_mode), 1);

    // R8 boundary: longest wait, code 7
    tag = "R8"; direct_irq_en = 1; target_sel = 0; settle_sel = 3'd7;
    pulse_sleep(); run(2150);
    chk("R8 long wait ends in active", int'(cur_mode), 0);
    // R8 boundary: shortest wait, code 0, after returning to subactive
    tag = "R6"; target_sel = 1; pulse_sleep(); run(140);
    tag = "R8"; target_sel = 0; settle_sel = 3'd0; pulse_sleep(); run(80);
    chk("R8 short wait ends in active", int'(cur_mode), 0);

    // R4: masked request locks sleep; wake ignored; reset clears
    tag = "R4"; irq_mask = 1; pulse_sleep(); run(3);
    pulse_wake(); run(3); pulse_wake(); run(10);
    chk("R4 still asleep after wake", int'(cur_mode), 2);
    rst_n = 1'b0; run(2); rst_n = 1'b1; irq_mask = 0; run(2);
    tag = "R1";
    chk("R1 reset leaves locked sleep", int'(cur_mode), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule